// File: doc/BRIEF.md
# Triggered Event Derandomizer Buffer

The block sits between a free-running front-end sample stream and a serial readout link. Every clock cycle it sees one sample from each of `NCH` parallel channels, each sample a 32-bit word. When a trigger is accepted, the block captures a readout window of `W` consecutive samples from all channels. It stores that window as one complete event in one of `DEPTH` event slots. Finished events leave in the order they were accepted, on one 32-bit valid/ready word stream. Each event starts with a header word that carries a 16-bit trigger sequence number.

Occupancy is counted in whole events. A trigger takes a slot only when a free slot exists. Otherwise the trigger is lost and counted as dead time. A separate counter holds the accepted triggers, so the lost fraction can be computed. A throttle with hysteresis warns the trigger system before the buffer fills. Windows may overlap: a trigger that arrives during a capture opens a second slot, and each sample cycle is written into every slot that is capturing at that time.

The states and transitions are these:

- **Slot FSM:**
  - `SLOT_FREE` goes to `SLOT_FILL` when the slot is allocated to an accepted trigger.
  - `SLOT_FILL` goes to `SLOT_READY` when the last window sample is written.
  - `SLOT_READY` goes back to `SLOT_FREE` when the drain releases the slot after its last word.
- **Drain FSM:**
  - `DR_IDLE` goes to `DR_HEAD` when the oldest slot is ready.
  - `DR_HEAD` goes to `DR_BODY` when the header word is taken.
  - `DR_BODY` goes back to `DR_IDLE` when the last data word is taken.
- **Throttle FSM:**
  - `TH_OPEN` goes to `TH_HELD` when free space falls to the threshold.
  - `TH_HELD` goes back to `TH_OPEN` when free space reaches the threshold plus two.

Top module: `event_derand`

## Requirements
- R1: An accepted trigger sampled at clock edge t captures the samples presented at edges t through t+W-1. W is `cfg_win` clamped to the range 10 to 55 and latched when the trigger is accepted.
- R2: The data words of an event are ordered sample by sample, and within one sample from channel 0 to NCH-1. Channel c is taken from `smp_data[32*c +: 32]`.
- R3: The first word of every event is a header whose bits 15:0 hold the trigger sequence number and whose bits 31:16 are zero. The number is 0 for the first accepted trigger after reset, rises by one per accepted trigger and wraps at 16 bits.
- R4: `out_sop` is high only on the header word and `out_eop` only on the last data word. An event is exactly 1 + W·NCH words long.
- R5: A trigger is accepted only if at least one event slot is free at the start of that cycle. Otherwise it is dropped whole, no part of it is stored, and `cnt_lost` rises by one. `ev_used` never exceeds `DEPTH`.
- R6: A trigger that comes fewer than `cfg_space` cycles after the previous accepted trigger is ignored. It changes neither counter and stores nothing.
- R7: When windows overlap, each shared sample cycle appears in both events.
- R8: Events leave in the order their triggers were accepted, and every accepted event leaves exactly once.
- R9: The throttle state register sets when free slots (`DEPTH - ev_used`) are at or below `cfg_thr`, and clears only when free slots are at or above `cfg_thr + 2`. `throttle` shows the result one cycle after the occupancy change.
- R10: `cnt_acc` counts accepted triggers.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values into the next cycle.
- R12: After reset, `out_valid`, `throttle`, `ev_used`, `cnt_acc` and `cnt_lost` are all zero.
- R13: `ev_used` reports the number of occupied event slots. A slot becomes occupied on acceptance and is freed on the handshake of its last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 1 | Trigger request, one cycle per trigger |
| smp_data | input | NCH*32 | One sample per channel, channel c in bits 32c+31:32c |
| cfg_win | input | $clog2(WMAX+1) | Readout window length in samples |
| cfg_space | input | SPW | Minimum spacing between accepted triggers, in cycles |
| cfg_thr | input | $clog2(DEPTH+1) | Throttle threshold in free events |
| out_data | output | 32 | Link word |
| out_valid | output | 1 | Link word valid |
| out_ready | input | 1 | Link accepts the word |
| out_sop | output | 1 | Header word of an event |
| out_eop | output | 1 | Last word of an event |
| throttle | output | 1 | Hold off triggers |
| ev_used | output | $clog2(DEPTH+1) | Occupied event slots |
| cnt_acc | output | CNTW | Accepted trigger count |
| cnt_lost | output | CNTW | Triggers lost to a full buffer |

## Verification
The embedded properties run on every cycle and cover these rules:
- occupancy never exceeds the slot count;
- the lost counter moves only when no slot was free;
- two triggers are never accepted back to back;
- a full buffer always holds the throttle;
- a slot is allocated only while free and released only while ready;
- a stalled word stays stable;
- no word is both header and trailer.

The bench scenarios are the only place where the following can be shown, because they depend on sample values and sequence:
- the window contents and their word order;
- sample sharing between overlapping windows;
- window clamping;
- header sequence numbers;
- the exact spacing cut-off;
- the hysteresis of the throttle as the buffer drains one event at a time.

// File: rtl/derand_pkg.sv
package derand_pkg;

    localparam int LINK_W = 32;
    localparam int SEQ_W  = 16;

    typedef enum logic [1:0] {
        SLOT_FREE,
        SLOT_FILL,
        SLOT_READY
    } slot_st_e;

    typedef enum logic [1:0] {
        DR_IDLE,
        DR_HEAD,
        DR_BODY
    } drain_st_e;

    typedef enum logic {
        TH_OPEN,
        TH_HELD
    } thr_st_e;

endpackage

// File: rtl/derand_slot.sv
module derand_slot
    import derand_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int WMAX  = 55,
    parameter int WIN_W = $clog2(WMAX + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    rel,
    input  logic [WIN_W-1:0]        win_in,
    input  logic [SEQ_W-1:0]        seq_in,
    input  logic [NCH*LINK_W-1:0]   smp_in,
    input  logic [WIN_W-1:0]        rd_idx,
    output logic [NCH*LINK_W-1:0]   rd_row,
    output logic [SEQ_W-1:0]        seq_out,
    output logic [WIN_W-1:0]        win_out,
    output logic                    is_ready
);

    slot_st_e                st_q, st_d;
    logic [WIN_W-1:0]        idx_q;
    logic [WIN_W-1:0]        win_q;
    logic [SEQ_W-1:0]        seq_q;
    logic                    wr_en;
    logic [WIN_W-1:0]        wr_addr;
    logic [NCH*LINK_W-1:0]   mem [WMAX];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SLOT_FREE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SLOT_FREE:  if (start)                    st_d = SLOT_FILL;
            SLOT_FILL:  if (idx_q == win_q - 1'b1)    st_d = SLOT_READY;
            SLOT_READY: if (rel)                      st_d = SLOT_FREE;
            default:                                  st_d = SLOT_FREE;
        endcase
    end

    // outputs and write strobes
    always_comb begin
        wr_en    = (st_q == SLOT_FREE && start) || (st_q == SLOT_FILL);
        wr_addr  = (st_q == SLOT_FILL) ? idx_q : '0;
        is_ready = (st_q == SLOT_READY);
        seq_out  = seq_q;
        win_out  = win_q;
        rd_row   = mem[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            win_q <= '0;
            seq_q <= '0;
        end else if (st_q == SLOT_FREE && start) begin
            idx_q <= WIN_W'(1);
            win_q <= win_in;
            seq_q <= seq_in;
        end else if (st_q == SLOT_FILL) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= smp_in;
    end

    // R5
    start_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> st_q == SLOT_FREE);

    // R8
    rel_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel |-> st_q == SLOT_READY);

endmodule

// File: rtl/derand_admit.sv
module derand_admit
    import derand_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int SPW   = 3,
    parameter int CNTW  = 16,
    parameter int EVW   = $clog2(DEPTH + 1),
    parameter int SLW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic [SPW-1:0]    cfg_space,
    input  logic [EVW-1:0]    cfg_thr,
    input  logic              rel,
    output logic              accept,
    output logic [SLW-1:0]    wr_slot,
    output logic [SEQ_W-1:0]  seq,
    output logic [EVW-1:0]    used,
    output logic              throttle,
    output logic [CNTW-1:0]   cnt_acc,
    output logic [CNTW-1:0]   cnt_lost
);

    thr_st_e          th_q, th_d;
    logic [SPW-1:0]   since_q;
    logic [EVW-1:0]   used_q;
    logic [EVW-1:0]   free;
    logic [EVW:0]     free_x, thr_x;
    logic [SLW-1:0]   slot_q;
    logic [SEQ_W-1:0] seq_q;
    logic [CNTW-1:0]  acc_q, lost_q;
    logic             spaced, lost;

    always_comb begin
        free   = EVW'(DEPTH) - used_q;
        spaced = (since_q >= cfg_space);
        accept = trig && spaced && (free != '0);
        lost   = trig && spaced && (free == '0);
        free_x = {1'b0, free};
        thr_x  = {1'b0, cfg_thr};
    end

    // throttle state register
    always_ff @(posedge clk) begin
        if (!rst_n) th_q <= TH_OPEN;
        else        th_q <= th_d;
    end

    // throttle next state
    always_comb begin
        th_d = th_q;
        unique case (th_q)
            TH_OPEN: if (free_x <= thr_x)                  th_d = TH_HELD;
            TH_HELD: if (free_x >= thr_x + (EVW+1)'(2))    th_d = TH_OPEN;
            default:                                       th_d = TH_OPEN;
        endcase
    end

    // outputs
    always_comb begin
        throttle = (th_q == TH_HELD);
        wr_slot  = slot_q;
        seq      = seq_q;
        used     = used_q;
        cnt_acc  = acc_q;
        cnt_lost = lost_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= '1;
            used_q  <= '0;
            slot_q  <= '0;
            seq_q   <= '0;
            acc_q   <= '0;
            lost_q  <= '0;
        end else begin
            if (accept)               since_q <= SPW'(1);
            else if (since_q != '1)   since_q <= since_q + 1'b1;
            used_q <= used_q + EVW'(accept) - EVW'(rel);
            if (accept) begin
                slot_q <= (slot_q == SLW'(DEPTH - 1)) ? '0 : slot_q + 1'b1;
                seq_q  <= seq_q + 1'b1;
                acc_q  <= acc_q + 1'b1;
            end
            if (lost) lost_q <= lost_q + 1'b1;
        end
    end

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        used_q <= EVW'(DEPTH));

    // R5
    lost_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(used_q) != EVW'(DEPTH)) |-> lost_q == $past(lost_q));

    // R6
    spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cfg_space >= SPW'(2)) |=> !accept);

    // R9
    full_throttle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(used_q) == EVW'(DEPTH)) |-> throttle);

endmodule

// File: rtl/derand_drain.sv
module derand_drain
    import derand_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int WIN_W = 6,
    parameter int DEPTH = 4,
    parameter int SLW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CHW   = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   slot_rdy,
    input  logic [NCH*LINK_W-1:0]  row_in,
    input  logic [SEQ_W-1:0]       seq_in,
    input  logic [WIN_W-1:0]       win_in,
    input  logic                   out_ready,
    output logic [SLW-1:0]         rd_slot,
    output logic [WIN_W-1:0]       rd_idx,
    output logic                   rel,
    output logic                   out_valid,
    output logic [LINK_W-1:0]      out_data,
    output logic                   out_sop,
    output logic                   out_eop
);

    drain_st_e         dr_q, dr_d;
    logic [CHW-1:0]    ch_q;
    logic [WIN_W-1:0]  idx_q;
    logic [SLW-1:0]    slot_q;
    logic              last_ch, last_word;

    always_comb begin
        last_ch   = (ch_q == CHW'(NCH - 1));
        last_word = (dr_q == DR_BODY) && last_ch && (idx_q == win_in - 1'b1);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) dr_q <= DR_IDLE;
        else        dr_q <= dr_d;
    end

    // next state
    always_comb begin
        dr_d = dr_q;
        unique case (dr_q)
            DR_IDLE: if (slot_rdy)               dr_d = DR_HEAD;
            DR_HEAD: if (out_ready)              dr_d = DR_BODY;
            DR_BODY: if (out_ready && last_word) dr_d = DR_IDLE;
            default:                             dr_d = DR_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        out_valid = 1'b0;
        out_sop   = 1'b0;
        out_eop   = 1'b0;
        out_data  = '0;
        unique case (dr_q)
            DR_IDLE: ;
            DR_HEAD: begin
                out_valid = 1'b1;
                out_sop   = 1'b1;
                out_data  = {{(LINK_W - SEQ_W){1'b0}}, seq_in};
            end
            DR_BODY: begin
                out_valid = 1'b1;
                out_eop   = last_word;
                out_data  = row_in[LINK_W*ch_q +: LINK_W];
            end
            default: ;
        endcase
        rel     = last_word && out_ready;
        rd_slot = slot_q;
        rd_idx  = idx_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q   <= '0;
            idx_q  <= '0;
            slot_q <= '0;
        end else begin
            if (dr_q == DR_HEAD) begin
                ch_q  <= '0;
                idx_q <= '0;
            end else if (dr_q == DR_BODY && out_ready) begin
                if (last_ch) begin
                    ch_q  <= '0;
                    idx_q <= idx_q + 1'b1;
                end else begin
                    ch_q  <= ch_q + 1'b1;
                end
            end
            if (rel) slot_q <= (slot_q == SLW'(DEPTH - 1)) ? '0 : slot_q + 1'b1;
        end
    end

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R4
    sop_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_sop && out_eop));

endmodule

// File: rtl/event_derand.sv
module event_derand
    import derand_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int DEPTH = 4,
    parameter int WMIN  = 10,
    parameter int WMAX  = 55,
    parameter int SPW   = 3,
    parameter int CNTW  = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          trig_in,
    input  logic [NCH*32-1:0]             smp_data,
    input  logic [$clog2(WMAX+1)-1:0]     cfg_win,
    input  logic [SPW-1:0]                cfg_space,
    input  logic [$clog2(DEPTH+1)-1:0]    cfg_thr,
    output logic [31:0]                   out_data,
    output logic                          out_valid,
    input  logic                          out_ready,
    output logic                          out_sop,
    output logic                          out_eop,
    output logic                          throttle,
    output logic [$clog2(DEPTH+1)-1:0]    ev_used,
    output logic [CNTW-1:0]               cnt_acc,
    output logic [CNTW-1:0]               cnt_lost
);

    localparam int WIN_W = $clog2(WMAX + 1);
    localparam int EVW   = $clog2(DEPTH + 1);
    localparam int SLW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIN_W-1:0]        win_eff;
    logic                    accept, rel;
    logic [SLW-1:0]          wr_slot, rd_slot;
    logic [SEQ_W-1:0]        seq_next;
    logic [WIN_W-1:0]        rd_idx;
    logic [NCH*LINK_W-1:0]   row_a [DEPTH];
    logic [SEQ_W-1:0]        seq_a [DEPTH];
    logic [WIN_W-1:0]        win_a [DEPTH];
    logic [DEPTH-1:0]        rdy_v;

    always_comb begin
        if (cfg_win < WIN_W'(WMIN))      win_eff = WIN_W'(WMIN);
        else if (cfg_win > WIN_W'(WMAX)) win_eff = WIN_W'(WMAX);
        else                             win_eff = cfg_win;
    end

    derand_admit #(
        .DEPTH (DEPTH),
        .SPW   (SPW),
        .CNTW  (CNTW),
        .EVW   (EVW),
        .SLW   (SLW)
    ) u_admit (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig_in),
        .cfg_space (cfg_space),
        .cfg_thr   (cfg_thr),
        .rel       (rel),
        .accept    (accept),
        .wr_slot   (wr_slot),
        .seq       (seq_next),
        .used      (ev_used),
        .throttle  (throttle),
        .cnt_acc   (cnt_acc),
        .cnt_lost  (cnt_lost)
    );

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        derand_slot #(
            .NCH   (NCH),
            .WMAX  (WMAX),
            .WIN_W (WIN_W)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .start    (accept && (wr_slot == SLW'(s))),
            .rel      (rel && (rd_slot == SLW'(s))),
            .win_in   (win_eff),
            .seq_in   (seq_next),
            .smp_in   (smp_data),
            .rd_idx   (rd_idx),
            .rd_row   (row_a[s]),
            .seq_out  (seq_a[s]),
            .win_out  (win_a[s]),
            .is_ready (rdy_v[s])
        );
    end

    derand_drain #(
        .NCH   (NCH),
        .WIN_W (WIN_W),
        .DEPTH (DEPTH),
        .SLW   (SLW)
    ) u_drain (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_rdy  (rdy_v[rd_slot]),
        .row_in    (row_a[rd_slot]),
        .seq_in    (seq_a[rd_slot]),
        .win_in    (win_a[rd_slot]),
        .out_ready (out_ready),
        .rd_slot   (rd_slot),
        .rd_idx    (rd_idx),
        .rel       (rel),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_sop   (out_sop),
        .out_eop   (out_eop)
    );

endmodule

// File: tb/test_event_derand.sv
`timescale 1ns/100ps
module test_event_derand;

    localparam int NCH = 4;
    localparam int DEPTH = 4;

    typedef struct {
        int seq;
        int k;
        int w;
    } ev_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              trig_in = 1'b0;
    logic [NCH*32-1:0] smp_data = '0;
    logic [5:0]        cfg_win = 6'd10;
    logic [2:0]        cfg_space = 3'd3;
    logic [2:0]        cfg_thr = 3'd1;
    logic [31:0]       out_data;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic              out_sop, out_eop, throttle;
    logic [2:0]        ev_used;
    logic [15:0]       cnt_acc, cnt_lost;

    int  n_vec = 0;
    int  n_fail = 0;
    int  smp_idx = 0;
    int  seq_exp = 0;
    int  cyc = 0;
    bit  done = 0;
    ev_t expq[$];

    always #2.5 clk = ~clk;

    event_derand i_event_derand (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .smp_data(smp_data),
        .cfg_win(cfg_win), .cfg_space(cfg_space), .cfg_thr(cfg_thr),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_sop(out_sop), .out_eop(out_eop), .throttle(throttle),
        .ev_used(ev_used), .cnt_acc(cnt_acc), .cnt_lost(cnt_lost)
    );

    function automatic logic [31:0] word_of(int k, int c);
        return {24'(k), 8'(c)};
    endfunction

    // sample stream: a new sample each cycle, changed away from the rising edge
    always @(negedge clk) begin
        smp_idx = smp_idx + 1;
        for (int c = 0; c < NCH; c++) smp_data[32*c +: 32] = word_of(smp_idx, c);
    end

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // driver: one trigger cycle, pushing the expected event when acceptance is foreseen
    task automatic fire(bit exp_acc, int w);
        ev_t e;
        @(negedge clk); #1;
        trig_in = 1'b1;
        if (exp_acc) begin
            e.seq = seq_exp; e.k = smp_idx; e.w = w;
            expq.push_back(e);
            seq_exp++;
        end
        @(negedge clk); #1;
        trig_in = 1'b0;
    endtask

    task automatic wait_empty();
        for (int i = 0; i < 3000; i++) begin
            if (expq.size() == 0 && !out_valid) break;
            idle(1);
        end
        idle(4);
    endtask

    task automatic drain_one();
        logic [2:0] prev;
        prev = ev_used;
        out_ready = 1'b1;
        for (int i = 0; i < 1000; i++) begin
            idle(1);
            if (ev_used < prev) break;
        end
        out_ready = 1'b0;
        idle(2);
    endtask

    // monitor: compares every transferred word against the scoreboard head
    initial begin
        ev_t cur;
        int  pos;
        bit  active;
        int  j, c;
        active = 0; pos = 0;
        cur.seq = 0; cur.k = 0; cur.w = 0;
        forever begin
            @(negedge clk); #2;
            if (rst_n && out_valid && out_ready) begin
                if (out_sop) begin
                    if (expq.size() == 0) begin
                        check(0, "R8 unexpected event", out_data, 32'h0);
                        active = 0;
                    end else begin
                        cur = expq.pop_front();
                        pos = 0;
                        active = 1;
                    end
                end
                if (active) begin
                    check(out_sop == (pos == 0), "R4 sop", 32'(out_sop), 32'(pos == 0));
                    check(out_eop == (pos == cur.w * NCH), "R4 eop",
                          32'(out_eop), 32'(pos == cur.w * NCH));
                    if (pos == 0) begin
                        check(out_data == 32'(cur.seq & 16'hFFFF), "R3 R8 header",
                              out_data, 32'(cur.seq & 16'hFFFF));
                    end else begin
                        j = (pos - 1) / NCH;
                        c = (pos - 1) % NCH;
                        check(out_data == word_of(cur.k + j, c), "R1 R2 R7 data",
                              out_data, word_of(cur.k + j, c));
                    end
                    if (out_eop) active = 0;
                    pos++;
                end else if (!out_sop) begin
                    check(0, "R4 word outside event", out_data, 32'h0);
                end
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
        end
    end

    initial begin
        logic [15:0] acc0, lost0;
        logic [31:0] d1;
        idle(4);
        rst_n = 1'b1;
        idle(1);
        // R12 reset state
        check(out_valid == 0, "R12 valid", 32'(out_valid), 0);
        check(throttle == 0, "R12 throttle", 32'(throttle), 0);
        check(ev_used == 0, "R12 used", 32'(ev_used), 0);
        check(cnt_acc == 0, "R12 acc", 32'(cnt_acc), 0);
        check(cnt_lost == 0, "R12 lost", 32'(cnt_lost), 0);

        // single event, W=10
        fire(1, 10);
        wait_empty();
        check(cnt_acc == 1, "R10 acc count", 32'(cnt_acc), 1);

        // overlapping windows, W=12, second trigger 3 cycles later (R7)
        cfg_win = 6'd12;
        fire(1, 12); idle(1); fire(1, 12);
        wait_empty();
        check(cnt_acc == 3, "R7 R10 acc count", 32'(cnt_acc), 3);

        // spacing: second trigger only 2 cycles later is ignored (R6)
        acc0 = cnt_acc; lost0 = cnt_lost;
        cfg_win = 6'd10;
        fire(1, 10); fire(0, 10);
        wait_empty();
        check(cnt_acc == acc0 + 1, "R6 acc unchanged by close trigger", 32'(cnt_acc), 32'(acc0 + 1));
        check(cnt_lost == lost0, "R6 lost unchanged by close trigger", 32'(cnt_lost), 32'(lost0));

        // clamping of the window (R1)
        cfg_win = 6'd5;
        fire(1, 10);
        wait_empty();
        cfg_win = 6'd60;
        fire(1, 55);
        wait_empty();
        check(ev_used == 0, "R13 used after drain", 32'(ev_used), 0);

        // fill the buffer with the link stalled
        cfg_win = 6'd10; cfg_thr = 3'd1;
        out_ready = 1'b0;
        fire(1, 10); idle(3);
        fire(1, 10); idle(2);
        check(throttle == 0, "R9 throttle open at 2 free", 32'(throttle), 0);
        fire(1, 10); idle(2);
        check(throttle == 1, "R9 throttle held at 1 free", 32'(throttle), 1);
        fire(1, 10); idle(15);
        check(ev_used == 4, "R13 used full", 32'(ev_used), 4);
        lost0 = cnt_lost;
        fire(0, 10); idle(3);
        check(cnt_lost == lost0 + 1, "R5 lost counted", 32'(cnt_lost), 32'(lost0 + 1));
        check(ev_used == 4, "R5 nothing stored", 32'(ev_used), 4);

        // stalled word holds (R11)
        d1 = out_data;
        idle(2);
        check(out_valid == 1, "R11 valid held", 32'(out_valid), 1);
        check(out_data == d1, "R11 data held", out_data, d1);

        // drain one event at a time, watching the hysteresis (R9)
        drain_one();
        check(throttle == 1, "R9 held at 1 free", 32'(throttle), 1);
        drain_one();
        check(throttle == 1, "R9 held at 2 free (hysteresis)", 32'(throttle), 1);
        drain_one();
        check(throttle == 0, "R9 released at 3 free", 32'(throttle), 0);
        drain_one();
        check(ev_used == 0, "R13 used empty", 32'(ev_used), 0);
        out_ready = 1'b1;
        wait_empty();

        check(expq.size() == 0, "R8 all events delivered", 32'(expq.size()), 0);
        check(cnt_acc == 16'(seq_exp), "R10 final acc", 32'(cnt_acc), 32'(seq_exp));
        check(cnt_lost == 1, "R5 final lost", 32'(cnt_lost), 1);
        summary();
    end

endmodule